// File: doc/BRIEF.md
# Display Data Channel Paged Read Engine

This block fetches a host-requested number of bytes from a display data channel and presents them to software one 64-byte page at a time. Bytes arrive from an external link layer on a valid/ready byte stream; the engine packs them into a sixteen-word buffer that the host reads over a simple 32-bit register bus. When a page fills, the engine stops accepting bytes until the host asks it to continue. Page-full, transfer-complete, hot-plug and link-error conditions are latched in write-one-to-clear flags that drive a maskable interrupt.

Software programs one control word that carries the byte count in bits [31:20], the transfer kind in bits [3:2], a continue request in bit 1 and a run bit in bit 0. The engine shows the transfer kind and its busy state to the link layer so that the link knows which kind of read to perform. Bus reads are combinational: `bus_rdata` shows the register at `bus_addr` in the same cycle. Control sits at byte address 0x00, interrupt enable at 0x04, status at 0x08, and buffer word i at 0x40 + 4*i.

Top module: `ddc_read_engine`

## Requirements
- R1: After reset the control, status and enable registers read zero, and `irq`, `in_ready` and `link_active` are low.
- R2: A control write with bit 0 set and a nonzero count in bits [31:20] while idle starts a transfer, with `in_ready` high from the next cycle. A zero count does not start one, and control bit 0 then reads back 0.
- R3: Byte n of a page is stored in buffer word n/4 at bit position 8*(n mod 4), so the first byte lands in bits [7:0] of word 0. Word i is read at address 0x40 + 4*i.
- R4: Once the 64th byte of a page is accepted, status bit 3 sets and `in_ready` stays low until the host writes control with bits 1 and 0 set. Fetching then resumes at word 0.
- R5: The continue bit (control bit 1) reads 1 only from its write until the engine resumes, and it then clears itself. A continue request written while the engine is not stalled on a full page is discarded.
- R6: After the last requested byte, status bit 2 sets and `in_ready` drops. A final partial page does not set bit 3, and the buffer bytes past its end keep their previous contents. A final page that is exactly full sets both bit 2 and bit 3.
- R7: Writing 1 to a status bit (bits 0, 2, 3, 4) clears it. Status bits written with 0 are unchanged.
- R8: A pulse on `hpd_evt` sets status bit 0 and a pulse on `err_evt` sets status bit 4. A new event wins over a clear of the same bit in the same cycle.
- R9: The enable register holds only bits 0, 2, 3 and 4. `irq` is high when some status bit and its enable bit are both 1, and an all-zero enable masks every source.
- R10: A control write with bit 0 clear ends any transfer, including one in progress, and `in_ready` and `link_active` drop. After completion, a control write with bit 0 set does not start a new transfer until bit 0 has been cleared.
- R11: `link_kind` shows the transfer kind written in control bits [3:2]. `link_active` is high from the start of a transfer until it completes or is ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| in_valid | input | 1 | Link byte valid |
| in_data | input | 8 | Link byte |
| in_ready | output | 1 | Engine accepts a byte |
| hpd_evt | input | 1 | Hot-plug event pulse |
| err_evt | input | 1 | Link error pulse |
| link_active | output | 1 | Transfer in progress (fetching or stalled on a full page) |
| link_kind | output | 2 | Transfer kind for the link layer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with its defaults: a sixteen-word buffer, a 12-bit count and the combinational interrupt variant. With these values a count of up to 150 crosses two page boundaries, so the bench reaches the stall and continue path, the exactly-full final page and the partial final page in a few hundred cycles. Random byte values and counts are checked against a bench model of the buffer. Directed cases cover a continue request sent while fetching, an ended transfer, a restart attempt after completion, and an event that arrives in the same cycle as a clear.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_FETCH     = 2'd1,
      ST_PAGE_WAIT = 2'd2,
      ST_FINISH    = 2'd3
   } ddc_state_e;

   localparam int FLAG_W   = 5;
   localparam int FLAG_HPD  = 0;
   localparam int FLAG_DONE = 2;
   localparam int FLAG_FULL = 3;
   localparam int FLAG_ERR  = 4;
   localparam logic [FLAG_W-1:0] FLAG_MASK = 5'b11101;
endpackage

// File: rtl/ddc_page_buf.sv
module ddc_page_buf #(
   parameter int WORDS = 16,
   parameter int PTR_W = 6,
   localparam int IDX_W = PTR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_we,
   input  logic [PTR_W-1:0]  byte_ptr,
   input  logic [7:0]        byte_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [31:0]       rd_word
);
   logic [WORDS-1:0][31:0] words;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar l = 0; l < 4; l++) begin : g_lane
         logic [7:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (byte_we && byte_ptr[PTR_W-1:2] == IDX_W'(w) && byte_ptr[1:0] == 2'(l))
               lane_q <= byte_data;
         end
         assign words[w][l*8 +: 8] = lane_q;
      end
   end

   assign rd_word = words[rd_idx];
endmodule

// File: rtl/ddc_fetch_ctrl.sv
module ddc_fetch_ctrl
   import ddc_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int PTR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              wr_run,
   input  logic              wr_cont,
   input  logic [1:0]        wr_kind,
   input  logic [CNT_W-1:0]  wr_cnt,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              byte_we,
   output logic [PTR_W-1:0]  byte_ptr,
   output logic              done_evt,
   output logic              full_evt,
   output ddc_state_e        state_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [1:0]        kind_q,
   output logic              cont_q
);
   logic [CNT_W-1:0] rem_q;
   logic [PTR_W-1:0] ptr_q;
   logic             take, last_byte, page_end;

   assign in_ready  = (state_q == ST_FETCH);
   assign take      = in_valid && in_ready;
   assign last_byte = (rem_q == CNT_W'(1));
   assign page_end  = &ptr_q;
   assign byte_we   = take;
   assign byte_ptr  = ptr_q;
   assign done_evt  = take && last_byte;
   assign full_evt  = take && page_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         ptr_q   <= '0;
         cnt_q   <= '0;
         kind_q  <= '0;
         cont_q  <= 1'b0;
      end else if (ctrl_we && state_q == ST_IDLE) begin
         cnt_q  <= wr_cnt;
         kind_q <= wr_kind;
         if (wr_run && wr_cnt != '0) begin
            state_q <= ST_FETCH;
            rem_q   <= wr_cnt;
            ptr_q   <= '0;
         end
      end else if (ctrl_we && !wr_run) begin
         state_q <= ST_IDLE;
         cont_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_FETCH: if (take) begin
               ptr_q <= ptr_q + PTR_W'(1);
               rem_q <= rem_q - CNT_W'(1);
               if (last_byte)
                  state_q <= ST_FINISH;
               else if (page_end)
                  state_q <= ST_PAGE_WAIT;
            end
            ST_PAGE_WAIT: begin
               if (cont_q) begin
                  state_q <= ST_FETCH;
                  cont_q  <= 1'b0;
               end else if (ctrl_we && wr_cont) begin
                  cont_q <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ddc_flag_regs.sv
module ddc_flag_regs
   import ddc_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic              ien_we,
   input  logic [FLAG_W-1:0] wdata,
   input  logic              hpd_evt,
   input  logic              err_evt,
   input  logic              done_evt,
   input  logic              full_evt,
   output logic [FLAG_W-1:0] stat_q,
   output logic [FLAG_W-1:0] ien_q,
   output logic              irq
);
   logic [FLAG_W-1:0] set_v, clr_v;
   logic              irq_c;

   always_comb begin
      set_v = '0;
      set_v[FLAG_HPD]  = hpd_evt;
      set_v[FLAG_DONE] = done_evt;
      set_v[FLAG_FULL] = full_evt;
      set_v[FLAG_ERR]  = err_evt;
      clr_v = stat_we ? (wdata & FLAG_MASK) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         ien_q  <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_v) | set_v;
         if (ien_we) ien_q <= wdata & FLAG_MASK;
      end
   end

   assign irq_c = |(stat_q & ien_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end
endmodule

// File: rtl/ddc_read_engine.sv
module ddc_read_engine
   import ddc_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUF_WORDS = 16,
   parameter int CNT_W     = 12,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   input  logic              hpd_evt,
   input  logic              err_evt,
   output logic              link_active,
   output logic [1:0]        link_kind,
   output logic              irq
);
   localparam int PAGE_BYTES = BUF_WORDS * 4;
   localparam int PTR_W      = $clog2(PAGE_BYTES);
   localparam int IDX_W      = PTR_W - 2;
   localparam int CNT_LSB    = 20;
   localparam int WA_W       = ADDR_W - 2;

   if (CNT_LSB + CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W does not fit above bit 20 of the control word");
   end
   if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_words
      $error("BUF_WORDS must be a power of two of at least 2");
   end
   if (ADDR_W <= PTR_W) begin : g_bad_addr
      $error("ADDR_W too small to map the buffer above the registers");
   end

   logic [WA_W-1:0]   word_addr;
   logic              sel_ctrl, sel_ien, sel_stat, sel_buf;
   ddc_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        kind_q;
   logic              cont_q;
   logic              byte_we, done_evt, full_evt;
   logic [PTR_W-1:0]  byte_ptr;
   logic [FLAG_W-1:0] stat_q, ien_q;
   logic [31:0]       buf_word, ctrl_view;
   logic              unused_bus;

   assign word_addr = bus_addr[ADDR_W-1:2];
   assign sel_ctrl  = (word_addr == WA_W'(0));
   assign sel_ien   = (word_addr == WA_W'(1));
   assign sel_stat  = (word_addr == WA_W'(2));
   assign sel_buf   = (bus_addr[ADDR_W-1:PTR_W] == (ADDR_W-PTR_W)'(1));
   assign unused_bus = ^{bus_wdata, bus_addr[1:0]};

   ddc_fetch_ctrl #(.CNT_W(CNT_W), .PTR_W(PTR_W)) fetch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (bus_wr && sel_ctrl),
      .wr_run   (bus_wdata[0]),
      .wr_cont  (bus_wdata[1]),
      .wr_kind  (bus_wdata[3:2]),
      .wr_cnt   (bus_wdata[CNT_LSB +: CNT_W]),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .byte_we  (byte_we),
      .byte_ptr (byte_ptr),
      .done_evt (done_evt),
      .full_evt (full_evt),
      .state_q  (state_q),
      .cnt_q    (cnt_q),
      .kind_q   (kind_q),
      .cont_q   (cont_q)
   );

   ddc_page_buf #(.WORDS(BUF_WORDS), .PTR_W(PTR_W)) buf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_we   (byte_we),
      .byte_ptr  (byte_ptr),
      .byte_data (in_data),
      .rd_idx    (bus_addr[PTR_W-1:2]),
      .rd_word   (buf_word)
   );

   ddc_flag_regs #(.IRQ_REG(IRQ_REG)) flags_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_we  (bus_wr && sel_stat),
      .ien_we   (bus_wr && sel_ien),
      .wdata    (bus_wdata[FLAG_W-1:0]),
      .hpd_evt  (hpd_evt),
      .err_evt  (err_evt),
      .done_evt (done_evt),
      .full_evt (full_evt),
      .stat_q   (stat_q),
      .ien_q    (ien_q),
      .irq      (irq)
   );

   always_comb begin
      ctrl_view = '0;
      ctrl_view[CNT_LSB +: CNT_W] = cnt_q;
      ctrl_view[3:2] = kind_q;
      ctrl_view[1]   = cont_q;
      ctrl_view[0]   = (state_q != ST_IDLE);
   end

   always_comb begin
      if (sel_buf)       bus_rdata = buf_word;
      else if (sel_ctrl) bus_rdata = ctrl_view;
      else if (sel_ien)  bus_rdata = 32'(ien_q);
      else if (sel_stat) bus_rdata = 32'(stat_q);
      else               bus_rdata = '0;
   end

   assign link_active = (state_q == ST_FETCH) || (state_q == ST_PAGE_WAIT);
   assign link_kind   = kind_q;
endmodule

// File: rtl/ddc_read_engine_chk.sv
module ddc_read_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic       in_ready,
   input logic       link_active,
   input logic       hpd_evt,
   input logic       err_evt,
   input logic       irq,
   input logic [4:0] stat_q,
   input logic [4:0] ien_q,
   input logic       cont_q
);
   assert_ready_in_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> link_active);

   assert_start_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> ($past(bus_wr) || $past(cont_q)));

   assert_full_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat_q[3]) && !stat_q[2]) |-> !in_ready);

   assert_cont_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cont_q |=> !cont_q);

   assert_done_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[2]) |-> !in_ready);

   assert_hpd_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hpd_evt |=> stat_q[0]);

   assert_err_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> stat_q[4]);

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == 5'd0 && $past(ien_q) == 5'd0) |-> !irq);
endmodule

bind ddc_read_engine ddc_read_engine_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .in_ready    (in_ready),
   .link_active (link_active),
   .hpd_evt     (hpd_evt),
   .err_evt     (err_evt),
   .irq         (irq),
   .stat_q      (stat_q),
   .ien_q       (ien_q),
   .cont_q      (cont_q)
);

// File: tb/ddc_read_engine_tb.sv
module ddc_read_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h04, A_STAT = 8'h08, A_BUF = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic        hpd_evt = 1'b0;
   logic        err_evt = 1'b0;
   logic        link_active;
   logic [1:0]  link_kind;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit reported = 1'b0;
   logic [7:0] ref_buf [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   ddc_read_engine dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .hpd_evt(hpd_evt), .err_evt(err_evt),
      .link_active(link_active), .link_kind(link_kind), .irq(irq)
   );

   function automatic logic [31:0] ctrl_word(int cnt, int kind, bit cont, bit run);
      return (32'(cnt) << 20) | (32'(kind & 3) << 2) | (32'(cont) << 1) | 32'(run);
   endfunction

   function automatic logic [31:0] exp_word(int w);
      return {ref_buf[4*w+3], ref_buf[4*w+2], ref_buf[4*w+1], ref_buf[4*w]};
   endfunction

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic push(logic [7:0] b);
      bit ok = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_data = b;
      for (int w = 0; w < 100; w++) begin
         if (in_ready) begin
            @(posedge clk);
            ok = 1'b1;
            break;
         end
         @(negedge clk);
      end
      #1;
      in_valid = 1'b0;
      if (!ok) chk("R2 byte accepted", 32'(in_ready), 32'd1);
   endtask

   task automatic cmp_buf(string req);
      logic [31:0] r;
      for (int w = 0; w < 16; w++) begin
         peek(A_BUF + 8'(4*w), r);
         chk(req, r, exp_word(w));
      end
   endtask

   task automatic run_xfer(int cnt, int kind, bit cont_early);
      logic [31:0] r;
      logic [31:0] cw = ctrl_word(cnt, kind, 1'b0, 1'b1);
      bus_write(A_CTRL, cw);
      chk("R2 ready after start", 32'(in_ready), 32'd1);
      chk("R11 active", 32'(link_active), 32'd1);
      chk("R11 kind", 32'(link_kind), 32'(kind & 3));
      for (int i = 0; i < cnt; i++) begin
         logic [7:0] b = 8'($urandom);
         push(b);
         ref_buf[i % 64] = b;
         if (cont_early && i == 5) begin
            bus_write(A_CTRL, cw | 32'h2);
            peek(A_CTRL, r);
            chk("R5 early continue dropped", 32'(r[1]), 32'd0);
         end
         if (i % 64 == 63 && i != cnt - 1) begin
            peek(A_STAT, r);
            chk("R4 full flag", r, 32'h08);
            chk("R9 irq on full", 32'(irq), 32'd1);
            repeat (3) @(negedge clk);
            chk("R4 stalled", 32'(in_ready), 32'd0);
            cmp_buf("R3 page contents");
            bus_write(A_STAT, 32'h08);
            peek(A_STAT, r);
            chk("R7 full cleared", r, 32'h0);
            bus_write(A_CTRL, cw | 32'h2);
            peek(A_CTRL, r);
            chk("R5 continue visible", 32'(r[1]), 32'd1);
            @(negedge clk);
            peek(A_CTRL, r);
            chk("R5 continue self-clears", 32'(r[1]), 32'd0);
            chk("R4 resumed", 32'(in_ready), 32'd1);
         end
      end
      peek(A_STAT, r);
      chk("R6 done flag", r, (cnt % 64 == 0) ? 32'h0C : 32'h04);
      chk("R6 ready low", 32'(in_ready), 32'd0);
      cmp_buf("R6 final buffer");
      bus_write(A_STAT, 32'h1D);
      peek(A_STAT, r);
      chk("R7 clear all", r, 32'h0);
      bus_write(A_CTRL, ctrl_word(cnt, kind, 1'b0, 1'b0));
      chk("R11 idle after end", 32'(link_active), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5eed_0d0c));
      for (int i = 0; i < 64; i++) ref_buf[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      peek(A_STAT, r); chk("R1 status", r, 32'h0);
      peek(A_IEN, r);  chk("R1 enable", r, 32'h0);
      peek(A_CTRL, r); chk("R1 control", r, 32'h0);
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 ready", 32'(in_ready), 32'd0);
      chk("R1 active", 32'(link_active), 32'd0);

      bus_write(A_IEN, 32'hFFFF_FFFF);
      peek(A_IEN, r); chk("R9 enable bits", r, 32'h1D);

      bus_write(A_CTRL, ctrl_word(0, 3, 1'b0, 1'b1));
      chk("R2 zero count idle", 32'(in_ready), 32'd0);
      peek(A_CTRL, r); chk("R2 zero count run bit", 32'(r[0]), 32'd0);

      run_xfer(70, 3, 1'b1);
      run_xfer(128, 2, 1'b0);
      run_xfer(3, 1, 1'b0);

      // R10: no restart after completion
      bus_write(A_CTRL, ctrl_word(2, 0, 1'b0, 1'b1));
      push(8'hA1); ref_buf[0] = 8'hA1;
      push(8'hB2); ref_buf[1] = 8'hB2;
      bus_write(A_CTRL, ctrl_word(5, 0, 1'b0, 1'b1));
      chk("R10 no restart", 32'(in_ready), 32'd0);
      peek(A_STAT, r); chk("R10 done kept", r, 32'h04);
      peek(A_BUF, r); chk("R3 little endian", r, exp_word(0));
      bus_write(A_STAT, 32'h04);
      bus_write(A_CTRL, 32'h0);

      // R10: end a transfer in progress
      bus_write(A_CTRL, ctrl_word(100, 1, 1'b0, 1'b1));
      for (int i = 0; i < 5; i++) begin
         logic [7:0] b = 8'($urandom);
         push(b); ref_buf[i] = b;
      end
      bus_write(A_CTRL, 32'h0);
      chk("R10 abort ready", 32'(in_ready), 32'd0);
      chk("R10 abort active", 32'(link_active), 32'd0);
      peek(A_STAT, r); chk("R10 abort no done", r, 32'h0);

      // R8 / R9: events and masking
      bus_write(A_IEN, 32'h01);
      @(negedge clk); err_evt = 1'b1;
      @(negedge clk); err_evt = 1'b0;
      peek(A_STAT, r); chk("R8 err flag", r, 32'h10);
      chk("R9 err masked", 32'(irq), 32'd0);
      @(negedge clk); hpd_evt = 1'b1;
      @(negedge clk); hpd_evt = 1'b0;
      peek(A_STAT, r); chk("R8 hpd flag", r, 32'h11);
      chk("R9 hpd irq", 32'(irq), 32'd1);
      @(negedge clk); hpd_evt = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h01;
      @(negedge clk); hpd_evt = 1'b0; bus_wr = 1'b0;
      peek(A_STAT, r); chk("R8 event beats clear", r, 32'h11);
      bus_write(A_STAT, 32'h01);
      peek(A_STAT, r); chk("R7 zero bits kept", r, 32'h10);
      bus_write(A_IEN, 32'h0);
      bus_write(A_STAT, 32'h01);
      @(negedge clk); hpd_evt = 1'b1;
      @(negedge clk); hpd_evt = 1'b0;
      chk("R9 all masked", 32'(irq), 32'd0);
      bus_write(A_STAT, 32'h1D);
      bus_write(A_IEN, 32'h1D);

      for (int t = 0; t < 6; t++) begin
         run_xfer(1 + int'($urandom % 150), int'($urandom % 4), 1'(($urandom % 2) == 1));
      end

      summary();
   end
endmodule